// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

This block keeps one free-running 64-bit tick counter and a set of compare channels that watch it. Software programs a channel with a target value. When the counter reaches that target the channel fires and raises its interrupt line. A channel runs in one of two modes. In single-shot mode it fires once and keeps its target. In repeating mode it adds its stored interval to the target each time it fires, so it fires again after that interval.

Each channel has its own interrupt signalling. A level-type channel sets a sticky status bit that software clears by writing 1 to it. An edge-type channel keeps no status and gives a one-cycle pulse. A channel can also be narrowed to a 32-bit compare. It then matches only the low half of the counter, and its repeating target wraps at 2^32.

Software reaches the block through a plain word-addressed port. Every register is 64 bits wide. A 32-bit access touches only the low half of a register. Reads return one cycle after the request.

Top module: `evt_timer`

## Requirements
- R1: The capability word at word address 0 reads as follows. Bits 7:0 hold REV_ID. Bits 12:8 hold the channel count minus one. Bit 13 reads 1 (64-bit counter). Bit 14 reads 0. Bit 15 reads 0 (no legacy routing). Bits 31:16 hold VENDOR_ID. Bits 63:32 hold the tick period PERIOD_FS.
- R2: While bit 0 of the global control word (address 1) is 1, the counter rises by exactly one each clock. While that bit is 0, the counter holds its value.
- R3: A write to the counter (address 3) takes effect only while the enable bit is 0. A write made while counting is ignored.
- R4: A single-shot channel fires once, when the counter equals its target. Firing leaves the target unchanged.
- R5: A repeating channel (config bit 3 = 1) adds its stored interval to its target each time it fires.
- R6: A target write has one of three effects. In single-shot mode it stores both the target and the interval. In repeating mode with the preset bit (config bit 6) set, it stores both, then clears the preset bit. In repeating mode without the preset bit, it stores the target only. Config bits 4 and 5 always read 1, and bits 63:32 read the fixed route mask ROUTE_MASK.
- R7: A level-type channel (config bit 1 = 1) sets its bit in the status word (address 2, bit n for channel n) when it fires. The bit stays set until a 1 is written to it. Writing 0 has no effect.
- R8: An edge-type channel (config bit 1 = 0) never sets its status bit. Its interrupt output is high for one cycle per firing.
- R9: A channel's interrupt output is held low while its interrupt enable (config bit 2) is 0. A level-type channel still records status while disabled.
- R10: With config bit 8 set, a channel compares only the low 32 bits of the counter. Its repeating advance wraps modulo 2^32 and leaves target bits 63:32 at zero.
- R11: With acc32 high, a write changes only bits 31:0 of the register, and a read returns bits 63:32 as zero.
- R12: Channel n's config register is at word address 8+2n and its target at 9+2n. Unmapped addresses read as zero. The read data is valid, with rvalid high, one cycle after req_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr | input | 1 | Write strobe |
| req_rd | input | 1 | Read strobe |
| acc32 | input | 1 | 32-bit access: low half only |
| addr | input | ADDR_W | 64-bit word address |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Registered read data |
| rvalid | output | 1 | Read data valid |
| irq | output | NUM_CH | Per-channel interrupt outputs |

## Verification
The first run checks the firing cycles against a queue of expected (channel, cycle) pairs. In that run, one repeating edge channel and one single-shot edge channel share a counter, while a level channel with its interrupt disabled fires unseen. This separates repeated firing from single firing, and pulse output from sticky output. A second run starts the counter just below a 32-bit boundary, with an upper half that does not match. It shows that a narrowed channel matches on the low half only and that its advance wraps. Status writes of 0 and of 1, and counter writes made while counting and while stopped, tell the hold cases apart from the clear and load cases.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int CNT_W   = 64;
  localparam int DATA_W  = 64;
  // word addresses of the global registers
  localparam int A_CAPS  = 0;
  localparam int A_GCFG  = 1;
  localparam int A_STS   = 2;
  localparam int A_CNT   = 3;
  localparam int CH_BASE = 8;
  // channel config bit positions (decoded by software)
  localparam int B_LVL   = 1;
  localparam int B_IE    = 2;
  localparam int B_PER   = 3;
  localparam int B_CPER  = 4;
  localparam int B_C64   = 5;
  localparam int B_VSET  = 6;
  localparam int B_M32   = 8;
endpackage

// File: rtl/evt_main_ctr.sv
module evt_main_ctr
  import evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             we,
  input  logic [CNT_W-1:0] wmask,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (run) cnt <= cnt + CNT_W'(1);
    else if (we)  cnt <= (cnt & ~wmask) | (wdata & wmask);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    run |=> cnt == $past(cnt) + CNT_W'(1)); // R2
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!run && !we) |=> $stable(cnt)); // R2
  AST_CNT_NOWR: assert property (@(posedge clk) disable iff (rst)
    (run && we) |=> cnt != $past(wdata) || $past(wdata) == $past(cnt) + CNT_W'(1)); // R3
endmodule

// File: rtl/evt_chan.sv
module evt_chan
  import evt_pkg::*;
#(
  parameter logic [31:0] ROUTE_MASK = 32'h00F0_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              run,
  input  logic              cfg_we,
  input  logic              cmp_we,
  input  logic [DATA_W-1:0] wmask,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sts_clr,
  output logic [DATA_W-1:0] cfg_rd,
  output logic [DATA_W-1:0] cmp_rd,
  output logic              sts,
  output logic              irq
);
  logic              lvl, ie, per, vset, m32;
  logic [CNT_W-1:0]  cmp, ival, cmp_new, adv;
  logic              match, fire, sts_nxt;

  always_comb begin
    cfg_rd         = '0;
    cfg_rd[63:32]  = ROUTE_MASK;
    cfg_rd[B_LVL]  = lvl;
    cfg_rd[B_IE]   = ie;
    cfg_rd[B_PER]  = per;
    cfg_rd[B_CPER] = 1'b1;
    cfg_rd[B_C64]  = 1'b1;
    cfg_rd[B_VSET] = vset;
    cfg_rd[B_M32]  = m32;
  end

  assign cmp_rd  = cmp;
  assign cmp_new = (cmp & ~wmask) | (wdata & wmask);
  assign match   = m32 ? (cnt[31:0] == cmp[31:0]) : (cnt == cmp);
  assign fire    = run && match;
  assign adv     = m32 ? {32'b0, cmp[31:0] + ival[31:0]} : cmp + ival;

  always_comb begin
    if (!lvl)         sts_nxt = 1'b0;
    else if (fire)    sts_nxt = 1'b1;
    else if (sts_clr) sts_nxt = 1'b0;
    else              sts_nxt = sts;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= 1'b0; ie <= 1'b0; per <= 1'b0; vset <= 1'b0; m32 <= 1'b0;
      cmp <= '0; ival <= '0; sts <= 1'b0; irq <= 1'b0;
    end else begin
      if (cfg_we) begin
        lvl  <= wdata[B_LVL];
        ie   <= wdata[B_IE];
        per  <= wdata[B_PER];
        vset <= wdata[B_VSET];
        m32  <= wdata[B_M32];
      end
      if (cmp_we) begin
        cmp <= cmp_new;
        if (!per || vset) ival <= cmp_new;
        if (per && vset)  vset <= 1'b0;
      end else if (fire && per) begin
        cmp <= adv;
      end
      sts <= sts_nxt;
      irq <= ie && (lvl ? sts_nxt : fire);
    end
  end

  AST_EDGE_NOSTS: assert property (@(posedge clk) disable iff (rst)
    (!lvl && !cfg_we) |=> !sts); // R8
  AST_STS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (lvl && sts && !sts_clr && !cfg_we) |=> sts); // R7
  AST_ONESHOT_CMP: assert property (@(posedge clk) disable iff (rst)
    (fire && !per && !cmp_we) |=> $stable(cmp)); // R4
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    (!ie && !cfg_we) |=> !irq); // R9
  AST_VSET_CLR: assert property (@(posedge clk) disable iff (rst)
    (cmp_we && per && vset) |=> !vset); // R6
  AST_M32_UPPER: assert property (@(posedge clk) disable iff (rst)
    (m32 && per && fire && !cmp_we && !cfg_we) |=> cmp[63:32] == 32'b0); // R10
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_pkg::*;
#(
  parameter int          NUM_CH     = 3,
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  REV_ID     = 8'h01,
  parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
  parameter logic [31:0] PERIOD_FS  = 32'd5000000,
  parameter logic [31:0] ROUTE_MASK = 32'h00F0_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic              acc32,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [NUM_CH-1:0] irq
);
  localparam logic [DATA_W-1:0] CAPS =
    {PERIOD_FS, VENDOR_ID, 1'b0, 1'b0, 1'b1, 5'(NUM_CH - 1), REV_ID};
  localparam logic [DATA_W-1:0] LOW_MASK = {32'b0, 32'hFFFF_FFFF};

  logic [DATA_W-1:0] wmask, rd_mux;
  logic [CNT_W-1:0]  cnt;
  logic              gen;
  logic [NUM_CH-1:0] ch_sts;
  logic [DATA_W-1:0] ch_cfg [NUM_CH];
  logic [DATA_W-1:0] ch_cmp [NUM_CH];
  logic              sts_we;

  assign wmask  = acc32 ? LOW_MASK : '1;
  assign sts_we = req_wr && (addr == ADDR_W'(A_STS));

  always_ff @(posedge clk) begin
    if (rst) gen <= 1'b0;
    else if (req_wr && addr == ADDR_W'(A_GCFG)) gen <= wdata[0];
  end

  evt_main_ctr u_ctr (
    .clk   (clk),
    .rst   (rst),
    .run   (gen),
    .we    (req_wr && addr == ADDR_W'(A_CNT)),
    .wmask (wmask),
    .wdata (wdata),
    .cnt   (cnt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    evt_chan #(.ROUTE_MASK(ROUTE_MASK)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .cnt     (cnt),
      .run     (gen),
      .cfg_we  (req_wr && addr == ADDR_W'(CH_BASE + 2*g)),
      .cmp_we  (req_wr && addr == ADDR_W'(CH_BASE + 2*g + 1)),
      .wmask   (wmask),
      .wdata   (wdata),
      .sts_clr (sts_we && wdata[g]),
      .cfg_rd  (ch_cfg[g]),
      .cmp_rd  (ch_cmp[g]),
      .sts     (ch_sts[g]),
      .irq     (irq[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(A_CAPS)) rd_mux = CAPS;
    if (addr == ADDR_W'(A_GCFG)) rd_mux = DATA_W'(gen);
    if (addr == ADDR_W'(A_STS))  rd_mux = DATA_W'(ch_sts);
    if (addr == ADDR_W'(A_CNT))  rd_mux = cnt;
    for (int n = 0; n < NUM_CH; n++) begin
      if (addr == ADDR_W'(CH_BASE + 2*n))     rd_mux = ch_cfg[n];
      if (addr == ADDR_W'(CH_BASE + 2*n + 1)) rd_mux = ch_cmp[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= req_rd;
      if (req_rd) rdata <= acc32 ? (rd_mux & LOW_MASK) : rd_mux;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    req_rd |=> rvalid); // R12
  AST_RD32_UPPER: assert property (@(posedge clk) disable iff (rst)
    (req_rd && acc32) |=> rdata[63:32] == 32'b0); // R11
endmodule

// File: tb/evt_timer_tb.sv
`timescale 1ns/1ps
module evt_timer_tb;
  localparam int NCH = 3;
  localparam logic [63:0] CAPS_EXP =
    {32'd5000000, 16'hA5C3, 1'b0, 1'b0, 1'b1, 5'd2, 8'h01};

  logic clk = 0, rst = 1, req_wr = 0, req_rd = 0, acc32 = 0;
  logic [7:0]  addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic        rvalid;
  logic [NCH-1:0] irq;

  int n_chk = 0, n_bad = 0;
  int exp_ch[$];
  int exp_k[$];

  always #2.5 clk = ~clk;

  evt_timer u_dut (
    .clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd), .acc32(acc32),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic h = 1'b0);
    @(posedge clk); #1;
    req_wr = 1; addr = a; wdata = d; acc32 = h;
    @(posedge clk); #1;
    req_wr = 0; acc32 = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic h, output logic [63:0] d);
    @(posedge clk); #1;
    req_rd = 1; addr = a; acc32 = h;
    @(posedge clk); #1;
    req_rd = 0; acc32 = 0;
    d = rdata;
    chk("R12 rvalid", 64'(rvalid), 64'd1);
  endtask

  task automatic push(input int c, input int k);
    exp_ch.push_back(c);
    exp_k.push_back(k);
  endtask

  // monitor: k = clock edges since the enable took effect
  task automatic monitor(input int ncyc, input logic [NCH-1:0] mask, input string tag);
    for (int k = 1; k <= ncyc; k++) begin
      @(posedge clk); #2;
      for (int c = 0; c < NCH; c++) begin
        if (mask[c] && irq[c]) begin
          n_chk++;
          if (exp_ch.size() == 0) begin
            n_bad++;
            $display("FAIL %s unexpected irq ch=%0d k=%0d exp=none", tag, c, k);
          end else begin
            int ec, ek;
            ec = exp_ch.pop_front();
            ek = exp_k.pop_front();
            if (ec != c || ek != k) begin
              n_bad++;
              $display("FAIL %s act ch=%0d k=%0d exp ch=%0d k=%0d", tag, c, k, ec, ek);
            end
          end
        end
      end
    end
    chk({tag, " leftover"}, 64'(exp_ch.size()), 64'd0);
    exp_ch.delete();
    exp_k.delete();
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d, d2;
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // reset state
    chk("R9 reset irq", 64'(irq), 64'd0);
    rd(8'd0, 1'b0, d);  chk("R1 caps", d, CAPS_EXP);
    rd(8'd1, 1'b0, d);  chk("R2 reset gcfg", d, 64'd0);
    rd(8'd2, 1'b0, d);  chk("R7 reset status", d, 64'd0);
    rd(8'd5, 1'b0, d);  chk("R12 unmapped", d, 64'd0);

    // channel setup, counter at 0, stopped
    wr(8'd8,  64'h4C);  // ch0 edge, ie, repeating, preset
    wr(8'd9,  64'd10);  // target and interval 10
    rd(8'd8, 1'b0, d);  chk("R6 preset cleared", d, {32'h00F0_0000, 32'h3C});
    wr(8'd10, 64'h04);  // ch1 edge, ie, single-shot
    wr(8'd11, 64'd15);
    wr(8'd12, 64'h02);  // ch2 level, interrupt disabled
    wr(8'd13, 64'd5);

    push(0, 11); push(1, 16); push(0, 21); push(0, 31); push(0, 41);
    wr(8'd1, 64'd1);
    monitor(48, 3'b011, "R5 R4 R8 run");

    wr(8'd3, 64'h0000_0009_0000_1234); // ignored while counting
    wr(8'd1, 64'd0);
    rd(8'd3, 1'b0, d);
    chk("R3 write ignored while counting", 64'(d >= 64'd48 && d < 64'd100), 64'd1);
    rd(8'd3, 1'b0, d2);
    chk("R2 counter holds when stopped", d2, d);
    rd(8'd11, 1'b0, d); chk("R4 single-shot target kept", d, 64'd15);
    rd(8'd2, 1'b0, d);  chk("R7 R8 status", d, 64'h4);
    chk("R9 disabled level irq", 64'(irq[2]), 64'd0);

    wr(8'd3, 64'h0000_0009_0000_1234);
    rd(8'd3, 1'b0, d);  chk("R3 write while stopped", d, 64'h0000_0009_0000_1234);

    // level interrupt and status clearing
    wr(8'd12, 64'h06);
    @(posedge clk); #1;
    chk("R7 level irq on enable", 64'(irq[2]), 64'd1);
    wr(8'd2, 64'h0);
    rd(8'd2, 1'b0, d);  chk("R7 write 0 no effect", d, 64'h4);
    chk("R7 irq still high", 64'(irq[2]), 64'd1);
    wr(8'd2, 64'h4);
    rd(8'd2, 1'b0, d);  chk("R7 write 1 clears", d, 64'h0);
    chk("R7 irq dropped", 64'(irq[2]), 64'd0);

    // 32-bit access
    wr(8'd3, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1);
    rd(8'd3, 1'b0, d);  chk("R11 half write", d, 64'h0000_0009_CCCC_DDDD);
    rd(8'd0, 1'b1, d);  chk("R11 half read", d, {32'h0, CAPS_EXP[31:0]});

    // narrowed compare across a 32-bit wrap
    wr(8'd3, 64'h0000_0005_FFFF_FFF0);
    wr(8'd8, 64'h14C);                  // m32, repeating, ie, preset
    wr(8'd9, 64'h10);                   // interval 0x10
    wr(8'd9, 64'h0000_0007_FFFF_FFF8);  // target only
    push(0, 9); push(0, 25);
    wr(8'd1, 64'd1);
    monitor(30, 3'b011, "R10 wrap run");
    wr(8'd1, 64'd0);
    rd(8'd9, 1'b0, d);  chk("R10 wrapped target", d, 64'h18);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule